// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block watches a vector of interrupt source lines and turns them into one request at a time for a processor. Each source has its own trigger mode (level, falling edge, rising edge or both edges) and its own pending flag. The flag is set by a detected trigger even while the source is disabled, so a source that is enabled later can still be served.

When no request is outstanding, the block picks the best enabled pending source. The best source is the one with the highest nonzero priority, and on a tie the lowest source number wins. The block presents that source as a 13-bit word made of a valid bit, a priority and a source number. The word goes out on the normal request output, or on the fast output when the fast-vector setting selects that source. The processor retires the request with a one-cycle acknowledge pulse. After that the block chooses again among the sources still pending.

Priorities are set per group rather than per source. A per-source map picks the group, so many sources can share one priority field. Enables, the group map, the group priorities and the fast-vector setting are plain configuration inputs. Trigger modes are held inside the block, start from a reset pattern fixed by a parameter, and can be rewritten one source at a time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both request outputs are zero. Each source whose bit is set in the LEVEL_MASK parameter starts in level mode, and every other source starts in rising-edge mode.
- R2: Trigger modes use a 2-bit code: 0 is level, 1 is falling edge, 2 is rising edge and 3 is both edges. Edge modes compare the current sample with the sample taken on the previous clock. A mode write (`mode_we`, `mode_idx`, `mode_val`) changes one source's code.
- R3: A level-mode source is pending exactly while its input is sampled high. When the input is sampled low, its flag clears, and if that source is the outstanding request, the request is withdrawn at the same clock edge.
- R4: A trigger sets the pending flag whatever the enable. A pending source is offered only while bit i of `cfg_enable` is set for source i, its priority is nonzero, and no request is outstanding.
- R5: A request word has the valid bit at bit 12, the priority in bits 11:8 and the source number in bits 7:0. A word without the valid bit is all zeros.
- R6: Source i uses group `cfg_group[i*GRP_W +: GRP_W]`, and group g has priority `cfg_prio[g*4 +: 4]`.
- R7: When `fast_vec[15]` is set and `fast_vec[7:0]` equals the granted source number, the word appears on `fiq_req` and `irq_req` stays zero. Otherwise the word appears on `irq_req` and `fiq_req` stays zero. The two outputs are never valid together.
- R8: An acknowledge while a request is outstanding frees the slot and clears the pending flag of that source, unless it is in level mode. An acknowledge while nothing is outstanding has no effect.
- R9: When the slot is free, the enabled pending source with the highest priority is granted, and on a tie the lowest source number wins. A priority of 0 is never granted.
- R10: A trigger sampled at edge k sets the pending flag, and the request word is visible after edge k+1. After an acknowledge sampled at edge k, both outputs are zero after edge k, and the next request is visible after edge k+1. While a request is outstanding its word does not change, and no other source is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt source lines |
| cfg_enable | input | NUM_SRC | Per-source enable, bit i for source i |
| cfg_group | input | NUM_SRC*GRP_W | Priority group chosen by each source |
| cfg_prio | input | NUM_GRP*4 | 4-bit priority of each group |
| fast_vec | input | 16 | Bit 15 enables fast routing; bits 7:0 give the fast source number |
| mode_we | input | 1 | Write strobe for a trigger mode |
| mode_idx | input | SRC_W | Source whose mode is written |
| mode_val | input | 2 | New trigger mode code |
| irq_ack | input | 1 | Acknowledge pulse from the processor |
| irq_req | output | 13 | Normal request word |
| fiq_req | output | 13 | Fast request word |

## Verification
The bench raises several sources while one request is outstanding. It then acknowledges them one by one, to show that a higher priority overtakes a lower source number, that a tie goes to the lower number, and that a priority-0 source is skipped. A faulty arbiter would hand out the wrong order or grant the masked source. Level-mode sources are the other main target. One must stay pending across an acknowledge and be requested again, and must be withdrawn the moment its line drops. A design that cleared it on acknowledge, or kept a stale request, would show a missing or lingering word. The bench also enables a source only after its pulse has gone, changes trigger codes at run time, and toggles the fast-vector match. These catch a design that gates the pending flag with the enable, misdecodes the mode codes, or sends the word to the wrong output.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int ID_W   = 8;
    localparam int PRIO_W = 4;
    localparam int WORD_W = 1 + PRIO_W + ID_W;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_RISE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } req_word_t;

    // True when the sampled pair (prev, cur) is the event the mode waits for.
    function automatic logic edge_hit(trig_e mode, logic cur, logic prev);
        case (mode)
            TRIG_FALL: return prev & ~cur;
            TRIG_RISE: return ~prev & cur;
            TRIG_BOTH: return prev ^ cur;
            default:   return cur;
        endcase
    endfunction

    function automatic logic fast_hit(logic en, logic [ID_W-1:0] sel,
                                      logic [ID_W-1:0] id);
        return en && (sel == id);
    endfunction

endpackage

// File: rtl/prio_irq_detect.sv
module prio_irq_detect
    import prio_irq_pkg::*;
#(
    parameter int                 NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    localparam int                SRC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               mode_we,
    input  logic [SRC_W-1:0]   mode_idx,
    input  logic [1:0]         mode_val,
    input  logic [NUM_SRC-1:0] clr_edge,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] level_low
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic  prev_q;
        logic  pend_q;
        trig_e mode_q;
        logic  hit;

        assign hit = edge_hit(mode_q, src_in[i], prev_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                mode_q <= LEVEL_MASK[i] ? TRIG_LEVEL : TRIG_RISE;
            end else begin
                prev_q <= src_in[i];
                if (mode_we && mode_idx == SRC_W'(i)) begin
                    mode_q <= trig_e'(mode_val);
                end
                if (mode_q == TRIG_LEVEL) begin
                    pend_q <= src_in[i];
                end else if (hit) begin
                    pend_q <= 1'b1;
                end else if (clr_edge[i]) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend[i]      = pend_q;
        assign level_low[i] = (mode_q == TRIG_LEVEL) && !src_in[i];
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int  NUM_SRC = 32,
    parameter int  GRP_W   = 4,
    localparam int NUM_GRP = 1 << GRP_W,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*GRP_W-1:0]  cfg_group,
    input  logic [NUM_GRP*PRIO_W-1:0] cfg_prio,
    output logic                      found,
    output logic [SRC_W-1:0]          win_id,
    output logic [PRIO_W-1:0]         win_prio
);

    logic [PRIO_W-1:0] src_prio [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lookup
        logic [GRP_W-1:0] grp;
        assign grp         = cfg_group[i*GRP_W +: GRP_W];
        assign src_prio[i] = cfg_prio[grp*PRIO_W +: PRIO_W];
    end

    // Ascending scan with a strict compare: ties keep the lower number,
    // and a zero priority can never beat the initial zero.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && src_prio[i] > win_prio) begin
                found    = 1'b1;
                win_id   = SRC_W'(i);
                win_prio = src_prio[i];
            end
        end
    end

endmodule

// File: rtl/prio_irq_slot.sv
module prio_irq_slot
    import prio_irq_pkg::*;
#(
    parameter int  NUM_SRC = 32,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               grant,
    input  logic [SRC_W-1:0]   grant_id,
    input  logic [PRIO_W-1:0]  grant_prio,
    input  logic [15:0]        fast_vec,
    input  logic               ack,
    input  logic [NUM_SRC-1:0] level_low,
    output req_word_t          cur,
    output logic               cur_fast,
    output logic [NUM_SRC-1:0] clr_edge
);

    logic             withdraw;
    logic [ID_W-1:0]  grant_id_w;
    logic             unused_fv;

    assign unused_fv  = ^fast_vec[14:8];
    assign grant_id_w = ID_W'(grant_id);
    assign withdraw   = cur.valid && level_low[cur.id[SRC_W-1:0]];

    always_comb begin
        clr_edge = '0;
        if (ack && cur.valid) begin
            clr_edge[cur.id[SRC_W-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            cur_fast <= 1'b0;
        end else if (cur.valid) begin
            if (ack || withdraw) begin
                cur      <= '0;
                cur_fast <= 1'b0;
            end
        end else if (grant) begin
            cur.valid <= 1'b1;
            cur.prio  <= grant_prio;
            cur.id    <= grant_id_w;
            cur_fast  <= fast_hit(fast_vec[15], fast_vec[7:0], grant_id_w);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                 NUM_SRC    = 32,
    parameter int                 GRP_W      = 4,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 32'h0000_00F0,
    localparam int                NUM_GRP    = 1 << GRP_W,
    localparam int                SRC_W      = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          src_in,
    input  logic [NUM_SRC-1:0]          cfg_enable,
    input  logic [NUM_SRC*GRP_W-1:0]    cfg_group,
    input  logic [NUM_GRP*PRIO_W-1:0]   cfg_prio,
    input  logic [15:0]                 fast_vec,
    input  logic                        mode_we,
    input  logic [SRC_W-1:0]            mode_idx,
    input  logic [1:0]                  mode_val,
    input  logic                        irq_ack,
    output logic [WORD_W-1:0]           irq_req,
    output logic [WORD_W-1:0]           fiq_req
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] level_low;
    logic [NUM_SRC-1:0] clr_edge;
    logic               found;
    logic [SRC_W-1:0]   win_id;
    logic [PRIO_W-1:0]  win_prio;
    req_word_t          cur;
    logic               cur_fast;

    prio_irq_detect #(
        .NUM_SRC   (NUM_SRC),
        .LEVEL_MASK(LEVEL_MASK)
    ) i_detect (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .mode_we  (mode_we),
        .mode_idx (mode_idx),
        .mode_val (mode_val),
        .clr_edge (clr_edge),
        .pend     (pend),
        .level_low(level_low)
    );

    prio_irq_arbiter #(
        .NUM_SRC(NUM_SRC),
        .GRP_W  (GRP_W)
    ) i_arb (
        .cand     (pend & cfg_enable),
        .cfg_group(cfg_group),
        .cfg_prio (cfg_prio),
        .found    (found),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    prio_irq_slot #(
        .NUM_SRC(NUM_SRC)
    ) i_slot (
        .clk       (clk),
        .rst       (rst),
        .grant     (found),
        .grant_id  (win_id),
        .grant_prio(win_prio),
        .fast_vec  (fast_vec),
        .ack       (irq_ack),
        .level_low (level_low),
        .cur       (cur),
        .cur_fast  (cur_fast),
        .clr_edge  (clr_edge)
    );

    assign irq_req = (cur.valid && !cur_fast) ? WORD_W'(cur) : '0;
    assign fiq_req = (cur.valid &&  cur_fast) ? WORD_W'(cur) : '0;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq_ack,
    input logic [12:0] irq_req,
    input logic [12:0] fiq_req
);

    // R1: reset empties both outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (irq_req == 13'd0 && fiq_req == 13'd0));

    // R5: an invalid word carries no fields
    a_r5_word_clean: assert property (@(posedge clk) disable iff (rst)
        (!irq_req[12] |-> irq_req == 13'd0) and (!fiq_req[12] |-> fiq_req == 13'd0));

    // R7: never both outputs at once
    a_r7_one_output: assert property (@(posedge clk) disable iff (rst)
        !(irq_req[12] && fiq_req[12]));

    // R8: an acknowledge frees the slot at the next edge
    a_r8_ack_frees: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && (irq_req[12] || fiq_req[12])) |=> (!irq_req[12] && !fiq_req[12]));

    // R9: a granted word never has priority zero
    a_r9_nonzero_prio: assert property (@(posedge clk) disable iff (rst)
        (irq_req[12] |-> irq_req[11:8] != 4'd0) and (fiq_req[12] |-> fiq_req[11:8] != 4'd0));

    // R10: an outstanding word holds until it is retired or withdrawn
    a_r10_word_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_req[12] && !irq_ack) |=> (irq_req == $past(irq_req) || irq_req == 13'd0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .irq_ack(irq_ack),
    .irq_req(irq_req),
    .fiq_req(fiq_req)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int GW   = 4;
    localparam int NGRP = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [NSRC-1:0]   src_in;
    logic [NSRC-1:0]   cfg_enable;
    logic [NSRC*GW-1:0] cfg_group;
    logic [NGRP*4-1:0] cfg_prio;
    logic [15:0]       fast_vec;
    logic              mode_we;
    logic [4:0]        mode_idx;
    logic [1:0]        mode_val;
    logic              irq_ack;
    logic [12:0]       irq_req;
    logic [12:0]       fiq_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .src_in(src_in), .cfg_enable(cfg_enable),
        .cfg_group(cfg_group), .cfg_prio(cfg_prio), .fast_vec(fast_vec),
        .mode_we(mode_we), .mode_idx(mode_idx), .mode_val(mode_val),
        .irq_ack(irq_ack), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    function automatic logic [12:0] word(int prio, int id);
        return {1'b1, 4'(prio), 8'(id)};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(int n);
        src_in[n] = 1'b1;
        tick();
        src_in[n] = 1'b0;
        tick();
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic set_mode(int n, int m);
        mode_we  = 1'b1;
        mode_idx = 5'(n);
        mode_val = 2'(m);
        tick();
        mode_we  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq_req, 13'd0);
        chk("R1 fiq after reset", fiq_req, 13'd0);
    endtask

    task automatic t_rising();
        pulse(1);
        chk("R2 R5 R6 R10 rising request", irq_req, word(1, 1));
        ack();
        chk("R8 ack frees slot", irq_req, 13'd0);
        tick(); tick();
        chk("R8 edge pending cleared", irq_req, 13'd0);
    endtask

    task automatic t_level();
        src_in[4] = 1'b1;
        tick(); tick();
        chk("R1 R3 level request", irq_req, word(4, 4));
        ack();
        chk("R8 level ack frees", irq_req, 13'd0);
        tick();
        chk("R8 level stays pending", irq_req, word(4, 4));
        src_in[4] = 1'b0;
        tick();
        chk("R3 level withdrawn", irq_req, 13'd0);
        tick();
        chk("R3 level no re-request", irq_req, 13'd0);
    endtask

    task automatic t_enable();
        cfg_enable[2] = 1'b0;
        pulse(2);
        tick();
        chk("R4 disabled not offered", irq_req, 13'd0);
        cfg_enable[2] = 1'b1;
        tick();
        chk("R4 pending kept while disabled", irq_req, word(2, 2));
        ack(); tick();
    endtask

    task automatic t_priority();
        pulse(3);
        chk("R10 first request", irq_req, word(3, 3));
        src_in[9] = 1'b1; src_in[25] = 1'b1; src_in[10] = 1'b1; src_in[16] = 1'b1;
        tick();
        src_in[9] = 1'b0; src_in[25] = 1'b0; src_in[10] = 1'b0; src_in[16] = 1'b0;
        tick();
        chk("R10 one outstanding", irq_req, word(3, 3));
        ack();
        chk("R10 gap after ack", irq_req, 13'd0);
        tick();
        chk("R9 highest priority", irq_req, word(10, 10));
        ack(); tick();
        chk("R9 tie lower number", irq_req, word(9, 9));
        ack(); tick();
        chk("R9 tie second", irq_req, word(9, 25));
        ack(); tick();
        chk("R9 zero priority skipped", irq_req, 13'd0);
    endtask

    task automatic t_fast();
        fast_vec = 16'h800C;
        pulse(12);
        chk("R7 fast output", fiq_req, word(12, 12));
        chk("R7 normal quiet", irq_req, 13'd0);
        ack();
        chk("R8 fast ack", fiq_req, 13'd0);
        fast_vec = 16'h000C;
        pulse(12);
        chk("R7 fast disabled normal", irq_req, word(12, 12));
        chk("R7 fast disabled fiq quiet", fiq_req, 13'd0);
        ack(); tick();
    endtask

    task automatic t_modes();
        set_mode(5, 1);
        src_in[5] = 1'b1;
        tick(); tick();
        chk("R2 falling ignores rise", irq_req, 13'd0);
        src_in[5] = 1'b0;
        tick(); tick();
        chk("R2 falling request", irq_req, word(5, 5));
        ack(); tick();
        set_mode(6, 3);
        src_in[6] = 1'b1;
        tick(); tick();
        chk("R2 both rise", irq_req, word(6, 6));
        ack(); tick();
        src_in[6] = 1'b0;
        tick(); tick();
        chk("R2 both fall", irq_req, word(6, 6));
        ack(); tick();
    endtask

    task automatic t_idle_ack();
        ack();
        chk("R8 idle ack ignored", irq_req, 13'd0);
        pulse(11);
        chk("R8 request after idle ack", irq_req, word(11, 11));
        ack(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; src_in = '0; cfg_enable = '1; fast_vec = 16'h0000;
        mode_we = 1'b0; mode_idx = '0; mode_val = '0; irq_ack = 1'b0;
        for (int i = 0; i < NSRC; i++) cfg_group[i*GW +: GW] = 4'(i % NGRP);
        for (int g = 0; g < NGRP; g++) cfg_prio[g*4 +: 4] = 4'(g);
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_rising();
        t_level();
        t_enable();
        t_priority();
        t_fast();
        t_modes();
        t_idle_ack();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule